// File: doc/BRIEF.md
# GPIO Pin Interrupt Sense Controller

This block watches twelve general-purpose input pins of one port and turns selected pin activity into interrupts. Each pin is brought into the clock domain through a two-stage synchroniser. Edges are found by comparing the synchronised value with a copy one cycle older. Three configuration bits per pin decide what counts as activity. A sense-type bit chooses edge or level. A both-edges bit makes any transition count. A polarity bit chooses falling/low (0) or rising/high (1). A mask bit then decides whether the pin may raise its own interrupt output and the combined interrupt line.

Software reaches the block through a small register port with write and read strobes, a 3-bit word address and 32-bit data. Edge events are sticky in a raw status register until software writes a 1 to the matching bit of a write-only clear register. Level conditions are not stored: they follow the synchronised pin. Read data is registered and appears one clock after the read strobe.

Top module: `gpio_irq_sense`

## Requirements
- R1: After reset all configuration registers read 0x000, both status registers read 0, and `pin_irq` and `any_irq` are 0.
- R2: Word addresses 0 (sense type), 1 (both edges), 2 (polarity) and 3 (mask) are read/write in bits 11:0. Bits 31:12 are ignored on write and read as zero. Read data appears on `rd_data` one clock after `rd_en`.
- R3: With sense type 0 (edge) and both-edges 0, polarity 1 makes a rising edge set the pin's raw status and polarity 0 makes a falling edge set it. The opposite edge has no effect. The status is set on the third rising clock edge after the pin changes.
- R4: With sense type 0 and both-edges 1, a rising edge and a falling edge both set the raw status, whatever the polarity bit holds.
- R5: Edge-set raw status stays set until a 1 is written to the same bit of the clear register at address 6. Clear bits written as 0 have no effect. Address 6 reads as zero.
- R6: With sense type 1 (level), raw status equals the synchronised pin when polarity is 1, and its inverse when polarity is 0. It follows the pin two clock edges after a change and is never latched.
- R7: Address 5 reads raw status AND mask. `pin_irq` equals that value, and `any_irq` is the OR of its bits. Writing mask 0 silences both outputs on the next cycle.
- R8: Writes to the raw status (address 4) and masked status (address 5) registers change no register.
- R9: If a clear write and a new qualifying edge on the same pin fall in the same cycle, the status bit stays set.
- R10: A clear write has no effect on a pin in level mode while its level condition holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pins_in | input | 12 | Asynchronous pin levels |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register word address |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| pin_irq | output | 12 | Per-pin masked interrupt |
| any_irq | output | 1 | OR of all per-pin interrupts |

## Verification
An edge event is due on the third rising clock edge after the pin moves. A level condition is due on the second. A register write takes effect at the edge between the strobe and its release, and read data at the edge after `rd_en`. The bench drives and samples on falling edges and counts those edges exactly. Edge tests check one cycle early that nothing is set yet, then check on the due cycle. The same-cycle clear case times the clear write to land on the exact edge where the event registers.

// File: rtl/gpio_irq_pkg.sv
// Package: shared sizes and register word addresses for the pin interrupt
// sense controller. Assumes a word-addressed register port.
package gpio_irq_pkg;
    localparam int unsigned REG_ADDR_W = 3;
    localparam int unsigned SYNC_DEPTH = 2;

    typedef enum logic [REG_ADDR_W-1:0] {
        RA_SENSE  = 3'd0,
        RA_BOTH   = 3'd1,
        RA_POL    = 3'd2,
        RA_MASK   = 3'd3,
        RA_RAW    = 3'd4,
        RA_MASKED = 3'd5,
        RA_CLEAR  = 3'd6
    } reg_addr_e;
endpackage

// File: rtl/gpio_irq_sync.sv
// Module: multi-stage pin synchroniser with a one-cycle-delayed copy of the
// last stage for edge detection. Assumes pins are low during reset.
module gpio_irq_sync #(
    parameter int unsigned WIDTH  = 12,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pins_async,
    output logic [WIDTH-1:0] cur_q,
    output logic [WIDTH-1:0] prev_q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    // Shift the pin levels through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) stage_q[k] <= '0;
        end else begin
            stage_q[0] <= pins_async;
            for (int k = 1; k < STAGES; k++) stage_q[k] <= stage_q[k-1];
        end
    end

    // Keep last cycle's synchronised value for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= stage_q[STAGES-1];
    end

    assign cur_q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_detect.sv
// Module: per-pin trigger qualification and raw status. Edge events are
// sticky until cleared; level conditions pass straight through.
// Assumes cur/prev come from the synchroniser.
module gpio_irq_detect #(
    parameter int unsigned NUM_PINS = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] cur,
    input  logic [NUM_PINS-1:0] prev,
    input  logic [NUM_PINS-1:0] level_mode,
    input  logic [NUM_PINS-1:0] any_edge,
    input  logic [NUM_PINS-1:0] high_rise,
    input  logic [NUM_PINS-1:0] clr,
    output logic [NUM_PINS-1:0] raw
);
    logic [NUM_PINS-1:0] rise;
    logic [NUM_PINS-1:0] fall;
    logic [NUM_PINS-1:0] hit;
    logic [NUM_PINS-1:0] lvl;
    logic [NUM_PINS-1:0] sticky_q;

    // Classify the transition seen this cycle on every pin.
    always_comb begin
        rise = cur & ~prev;
        fall = ~cur & prev;
    end

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        // Decide whether this pin's transition qualifies as an event.
        always_comb begin
            if (level_mode[i])     hit[i] = 1'b0;
            else if (any_edge[i])  hit[i] = rise[i] | fall[i];
            else if (high_rise[i]) hit[i] = rise[i];
            else                   hit[i] = fall[i];
        end

        // Level condition: active-high or active-low by polarity.
        always_comb lvl[i] = high_rise[i] ? cur[i] : ~cur[i];

        // Hold an edge event until cleared; a new event beats a clear.
        always_ff @(posedge clk) begin
            if (!rst_n)      sticky_q[i] <= 1'b0;
            else if (hit[i]) sticky_q[i] <= 1'b1;
            else if (clr[i]) sticky_q[i] <= 1'b0;
        end

        // Raw status comes from the level or the stored event.
        always_comb raw[i] = level_mode[i] ? lvl[i] : sticky_q[i];

        // R3: a stored event only appears after a qualifying edge.
        p_event_needs_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(sticky_q[i]) |-> $past(hit[i]));

        // R9: a clear colliding with a new event leaves the event stored.
        p_collision_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (hit[i] && clr[i]) |=> sticky_q[i]);
    end
endmodule

// File: rtl/gpio_irq_regs.sv
// Module: configuration registers, clear strobe and registered read mux.
// Assumes a single-cycle write strobe and word addresses from gpio_irq_pkg.
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NUM_PINS = 12,
    parameter int unsigned DATA_W   = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [REG_ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic [NUM_PINS-1:0]   raw_st,
    input  logic [NUM_PINS-1:0]   masked_st,
    output logic [NUM_PINS-1:0]   sense_q,
    output logic [NUM_PINS-1:0]   both_q,
    output logic [NUM_PINS-1:0]   pol_q,
    output logic [NUM_PINS-1:0]   mask_q,
    output logic [NUM_PINS-1:0]   clr_pulse,
    output logic [DATA_W-1:0]     rd_data
);
    logic [NUM_PINS-1:0] wr_bits;
    logic [DATA_W-1:0]   rd_next;

    assign wr_bits = wr_data[NUM_PINS-1:0];

    if (DATA_W > NUM_PINS) begin : g_hi
        logic unused_hi;
        assign unused_hi = ^wr_data[DATA_W-1:NUM_PINS];
    end

    // Capture writes to the four read/write configuration words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sense_q <= '0;
            both_q  <= '0;
            pol_q   <= '0;
            mask_q  <= '0;
        end else if (wr_en) begin
            case (reg_addr_e'(addr))
                RA_SENSE: sense_q <= wr_bits;
                RA_BOTH:  both_q  <= wr_bits;
                RA_POL:   pol_q   <= wr_bits;
                RA_MASK:  mask_q  <= wr_bits;
                default:  ;
            endcase
        end
    end

    // Turn a write to the clear word into a one-cycle per-pin pulse.
    always_comb clr_pulse = (wr_en && addr == RA_CLEAR) ? wr_bits : '0;

    // Select the word to return; unused and write-only words read zero.
    always_comb begin
        case (reg_addr_e'(addr))
            RA_SENSE:  rd_next = DATA_W'(sense_q);
            RA_BOTH:   rd_next = DATA_W'(both_q);
            RA_POL:    rd_next = DATA_W'(pol_q);
            RA_MASK:   rd_next = DATA_W'(mask_q);
            RA_RAW:    rd_next = DATA_W'(raw_st);
            RA_MASKED: rd_next = DATA_W'(masked_st);
            default:   rd_next = '0;
        endcase
    end

    // Register read data on the read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_next;
    end

    // R8: writes to the status words leave every configuration word alone.
    p_status_write_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr == RA_RAW || addr == RA_MASKED))
        |=> $stable({sense_q, both_q, pol_q, mask_q}));

    // R5: the clear word is write-only and reads back as zero.
    p_clear_reads_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == RA_CLEAR) |=> (rd_data == '0));
endmodule

// File: rtl/gpio_irq_sense.sv
// Module: top of the pin interrupt sense controller. Ties synchroniser,
// trigger detection and registers together and forms the interrupt outputs.
// Assumes pins_in is asynchronous and low while reset is held.
module gpio_irq_sense
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NUM_PINS = 12,
    parameter int unsigned DATA_W   = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PINS-1:0]   pins_in,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [REG_ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0]     wr_data,
    output logic [DATA_W-1:0]     rd_data,
    output logic [NUM_PINS-1:0]   pin_irq,
    output logic                  any_irq
);
    logic [NUM_PINS-1:0] cur;
    logic [NUM_PINS-1:0] prev;
    logic [NUM_PINS-1:0] sense_q;
    logic [NUM_PINS-1:0] both_q;
    logic [NUM_PINS-1:0] pol_q;
    logic [NUM_PINS-1:0] mask_q;
    logic [NUM_PINS-1:0] clr_pulse;
    logic [NUM_PINS-1:0] raw_st;
    logic [NUM_PINS-1:0] masked_st;

    gpio_irq_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_DEPTH)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .pins_async (pins_in),
        .cur_q      (cur),
        .prev_q     (prev)
    );

    gpio_irq_detect #(.NUM_PINS(NUM_PINS)) u_detect (
        .clk        (clk),
        .rst_n      (rst_n),
        .cur        (cur),
        .prev       (prev),
        .level_mode (sense_q),
        .any_edge   (both_q),
        .high_rise  (pol_q),
        .clr        (clr_pulse),
        .raw        (raw_st)
    );

    gpio_irq_regs #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .addr      (addr),
        .wr_data   (wr_data),
        .raw_st    (raw_st),
        .masked_st (masked_st),
        .sense_q   (sense_q),
        .both_q    (both_q),
        .pol_q     (pol_q),
        .mask_q    (mask_q),
        .clr_pulse (clr_pulse),
        .rd_data   (rd_data)
    );

    // Gate raw status by the mask and combine into the shared line.
    always_comb begin
        masked_st = raw_st & mask_q;
        pin_irq   = masked_st;
        any_irq   = |masked_st;
    end

    // R7: writing an all-zero mask silences every interrupt next cycle.
    p_mask_all_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == RA_MASK && wr_data[NUM_PINS-1:0] == '0)
        |=> (!any_irq && pin_irq == '0));
endmodule

// File: tb/tb_gpio_irq_sense.sv
module tb_gpio_irq_sense;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] pins_in = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [11:0] pin_irq;
    logic        any_irq;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    gpio_irq_sense dut (
        .clk(clk), .rst_n(rst_n), .pins_in(pins_in), .wr_en(wr_en),
        .rd_en(rd_en), .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
        .pin_irq(pin_irq), .any_irq(any_irq)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic rd_check(input logic [2:0] a, input logic [31:0] exp, input string tag);
        logic [31:0] v;
        rd(a, v);
        check(v == exp, tag, v, exp);
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
        wr(3'd6, 32'hFFF);
    endtask

    task automatic t_reset();
        check(pin_irq == 12'h0, "R1 pin_irq", 32'(pin_irq), 0);
        check(any_irq == 1'b0, "R1 any_irq", 32'(any_irq), 0);
        for (int a = 0; a < 7; a++) rd_check(3'(a), 32'h0, "R1 register reset");
    endtask

    task automatic t_regs();
        wr(3'd0, 32'hFFFF_F0A5);
        wr(3'd1, 32'h1234_55A3);
        wr(3'd2, 32'h0000_03C3);
        wr(3'd3, 32'hFFFF_FFFF);
        rd_check(3'd0, 32'h0A5, "R2 sense word");
        rd_check(3'd1, 32'h5A3, "R2 both word");
        rd_check(3'd2, 32'h3C3, "R2 polarity word");
        rd_check(3'd3, 32'hFFF, "R2 mask word");
        for (int a = 0; a < 4; a++) wr(3'(a), 32'h0);
        settle();
    endtask

    task automatic t_edge_pol();
        wr(3'd3, 32'hFFF);
        wr(3'd2, 32'h001);
        @(negedge clk); pins_in = 12'h003;
        repeat (2) @(negedge clk);
        check(pin_irq == 12'h000, "R3 not before third edge", 32'(pin_irq), 0);
        @(negedge clk);
        check(pin_irq == 12'h001, "R3 rising sets pol1 only", 32'(pin_irq), 32'h001);
        check(any_irq == 1'b1, "R7 any_irq on event", 32'(any_irq), 1);
        @(negedge clk); pins_in = 12'h000;
        repeat (3) @(negedge clk);
        check(pin_irq == 12'h003, "R3 falling sets pol0", 32'(pin_irq), 32'h003);
        wr(3'd2, 32'h0);
        settle();
    endtask

    task automatic t_both();
        wr(3'd1, 32'h004);
        wr(3'd2, 32'h004);
        @(negedge clk); pins_in = 12'h004;
        repeat (3) @(negedge clk);
        check(pin_irq == 12'h004, "R4 rise with both-edges", 32'(pin_irq), 32'h004);
        wr(3'd6, 32'h004);
        wr(3'd2, 32'h000);
        @(negedge clk); pins_in = 12'h000;
        repeat (3) @(negedge clk);
        check(pin_irq == 12'h004, "R4 fall with both-edges", 32'(pin_irq), 32'h004);
    endtask

    task automatic t_ro_and_mask();
        wr(3'd4, 32'h0);
        wr(3'd5, 32'h0);
        rd_check(3'd4, 32'h004, "R8 raw write ignored");
        rd_check(3'd1, 32'h004, "R8 both word unchanged");
        wr(3'd3, 32'h000);
        check(pin_irq == 12'h0 && !any_irq, "R7 mask off silences", 32'(pin_irq), 0);
        rd_check(3'd4, 32'h004, "R7 raw before masking");
        rd_check(3'd5, 32'h000, "R7 masked status off");
        wr(3'd3, 32'h004);
        rd_check(3'd5, 32'h004, "R7 masked status on");
        check(any_irq == 1'b1, "R7 any_irq on", 32'(any_irq), 1);
    endtask

    task automatic t_sticky();
        wr(3'd6, 32'hFFB);
        check(pin_irq == 12'h004, "R5 zero clear bit no effect", 32'(pin_irq), 32'h004);
        rd_check(3'd6, 32'h0, "R5 clear word reads zero");
        wr(3'd6, 32'h004);
        check(pin_irq == 12'h000, "R5 clear drops status", 32'(pin_irq), 0);
        wr(3'd1, 32'h0);
        settle();
    endtask

    task automatic t_level();
        wr(3'd0, 32'h008);
        wr(3'd2, 32'h008);
        wr(3'd3, 32'h008);
        @(negedge clk); pins_in = 12'h008;
        @(negedge clk);
        check(pin_irq == 12'h000, "R6 level not yet", 32'(pin_irq), 0);
        @(negedge clk);
        check(pin_irq == 12'h008, "R6 high level", 32'(pin_irq), 32'h008);
        @(negedge clk); pins_in = 12'h000;
        repeat (2) @(negedge clk);
        check(pin_irq == 12'h000, "R6 level not latched", 32'(pin_irq), 0);
        wr(3'd2, 32'h000);
        check(pin_irq == 12'h008, "R6 low level", 32'(pin_irq), 32'h008);
        wr(3'd6, 32'h008);
        check(pin_irq == 12'h008, "R10 clear ignored in level", 32'(pin_irq), 32'h008);
        rd_check(3'd4, 32'h008, "R10 raw still set");
        wr(3'd0, 32'h0);
        settle();
    endtask

    task automatic t_collision();
        wr(3'd1, 32'h010);
        wr(3'd3, 32'h010);
        @(negedge clk); pins_in = 12'h010;
        repeat (3) @(negedge clk);
        check(pin_irq == 12'h010, "R9 first event", 32'(pin_irq), 32'h010);
        @(negedge clk); pins_in = 12'h000;
        @(negedge clk);
        wr(3'd6, 32'h010);
        check(pin_irq == 12'h010, "R9 event beats clear", 32'(pin_irq), 32'h010);
        wr(3'd6, 32'h010);
        check(pin_irq == 12'h000, "R5 later clear drops", 32'(pin_irq), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_edge_pol();
        t_both();
        t_ro_and_mask();
        t_sticky();
        t_level();
        t_collision();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule